// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Page Buffer

This block is the serial front end of a 128-byte non-volatile store. It sits on a two-wire bus as a slave. The clock and data lines reach it already oversampled by the system clock. It pulls the data line low through a single output-enable, and it reaches the storage array through a plain write port and a combinational read port. A master addresses the block with a fixed 7-bit identity. It can set a word pointer, stream data into an 8-byte page buffer, and read bytes back one at a time or as a stream.

A stop condition after buffered data starts a self-timed commit, whose length in system clocks is a parameter. During the commit the buffered bytes go to the array within the page picked by the pointer's upper bits. For the whole commit the block ignores the bus and gives no acknowledge, so a master polls with its address until it is acknowledged again. A level input acts as a write enable. If that level is seen low at any time between the start and the stop of a write frame, the frame leaves the array untouched. Level changes during the commit have no effect.

Top module: `ddc_eeprom_slave`

## Requirements
- R1: The block acknowledges (pulls SDA low during the ninth clock) a control byte only when its upper 7 bits equal 1010000; bit 0 is the direction, 1 meaning read and 0 meaning write. Any other control byte gets no acknowledge, and the block stays silent until the next start condition.
- R2: In a write frame, the byte after the control byte loads the 7-bit word pointer (its top bit is ignored), and every following data byte is acknowledged.
- R3: Each data byte goes to the buffer slot given by the pointer's low 3 bits. Only those 3 bits then increment, wrapping inside the 8-byte page, and all committed addresses share the pointer's upper 4 bits.
- R4: When more than 8 data bytes are sent, later bytes overwrite earlier slots, so each slot holds the last byte sent to it, and a commit writes at most 8 array locations.
- R5: A stop condition after at least one data byte starts a commit. The array write port is active only during the commit, the commit lasts exactly WR_CYCLES clocks, and each received slot is written exactly once.
- R6: While a commit is in progress the block acknowledges nothing, including its own address. Once the commit ends, it acknowledges its address again.
- R7: The commit happens only if the write-enable level is high at every clock from the frame's start to its stop. A low sample anywhere discards the frame, while changes during the commit do not stop it.
- R8: A read frame with no preceding pointer load returns the byte at the pointer. That is the last accessed address plus one: after a read of n it is n+1, and after writes it is the in-page successor of the last byte written.
- R9: In a read, each master acknowledge moves to the next byte, with the 7-bit pointer wrapping from 0x7F to 0x00. A master non-acknowledge makes the block release SDA and end the transfer.
- R10: A random read (pointer load, repeated start, read control byte) returns the byte at the loaded address. A repeated start in place of a stop cancels any buffered write data, so no commit follows.
- R11: While in reset and after it, SDA is released and the array write port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (as seen on the wired bus) |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| wp_vclk_i | input | 1 | Write-enable level; high permits programming |
| mem_we_o | output | 1 | Array write strobe |
| mem_waddr_o | output | 7 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| mem_raddr_o | output | 7 | Array read address (the word pointer) |
| mem_rdata_i | input | 8 | Array read data, combinational from mem_raddr_o |

## Verification
The hardest situation to reach from the ports is a control byte that arrives while a commit is still running. It needs a stop, then a new frame that gets through eight address bits before WR_CYCLES clocks have passed. The bench therefore sets a commit length of a few polling frames and starts polling right after every stop. It expects the first poll to be refused and a later one to be acknowledged. A second hard case is a write-enable dip of a few clocks hidden inside a data byte. The bench drops the level briefly while SCL is low in the middle of a page write, then confirms that no array write happened and that the very next poll is acknowledged at once.

// File: rtl/ddc_eeprom_pkg.sv
package ddc_eeprom_pkg;

  // bus-side phase of the slave
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_t;

  // meaning of the byte currently being received
  typedef enum logic [1:0] {
    RK_CTRL,
    RK_WADDR,
    RK_DATA
  } rxkind_t;

endpackage

// File: rtl/twi_line_monitor.sv
module twi_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic scl_q;
  logic sda_q;
  logic scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_STAGES-1];
      sda_q  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & ~sda_lvl & sda_q;
  assign stop_det  = scl_lvl & scl_q & sda_lvl & ~sda_q;

endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int PAGE_BYTES = 8,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_valid
);

  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PAGE_BYTES-1:0] vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr) begin
      vld_d = '0;
    end else if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (wr_en && (wr_idx == PW'(i))) begin
        slot_q[i] <= wr_data;
      end
    end
  end

  assign rd_data  = slot_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];

endmodule

// File: rtl/write_engine.sv
module write_engine #(
  parameter int ADDR_W     = 7,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 200,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int BW = ADDR_W - PW,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [BW-1:0]     page_base,
  input  logic              slot_valid,
  output logic [PW-1:0]     slot_idx,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW:0]   ci_q, ci_d;
  logic [BW-1:0] base_q, base_d;

  always_comb begin
    cnt_d  = cnt_q;
    ci_d   = ci_q;
    base_d = base_q;
    if (launch && (cnt_q == '0)) begin
      cnt_d  = CW'(WR_CYCLES);
      ci_d   = '0;
      base_d = page_base;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (!ci_q[PW]) begin
        ci_d = ci_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ci_q   <= {1'b1, {PW{1'b0}}};
      base_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ci_q   <= ci_d;
      base_q <= base_d;
    end
  end

  assign busy     = (cnt_q != '0);
  assign slot_idx = ci_q[PW-1:0];
  assign we       = busy && !ci_q[PW] && slot_valid;
  assign waddr    = {base_q, ci_q[PW-1:0]};

endmodule

// File: rtl/ddc_eeprom_slave.sv
module ddc_eeprom_slave
  import ddc_eeprom_pkg::*;
#(
  parameter int          ADDR_W      = 7,
  parameter int          PAGE_BYTES  = 8,
  parameter int          WR_CYCLES   = 200,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ID      = 7'b1010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              wp_vclk_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [7:0]        mem_rdata_i
);

  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = ADDR_W - PW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  twi_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // protocol state
  phase_t            phase_q, phase_d;
  rxkind_t           kind_q, kind_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [7:0]        txreg_q, txreg_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              oe_q, oe_d;
  logic              mack_q, mack_d;
  logic              to_tx_q, to_tx_d;
  logic              wp_ok_q, wp_ok_d;
  logic              in_frame_q, in_frame_d;
  logic              wr_armed_q, wr_armed_d;

  logic              buf_clr, buf_we;
  logic              launch;
  logic              wr_busy;
  logic [PW-1:0]     eng_idx;
  logic [7:0]        eng_data;
  logic              eng_valid;

  always_comb begin
    phase_d    = phase_q;
    kind_d     = kind_q;
    bitcnt_d   = bitcnt_q;
    shreg_d    = shreg_q;
    txreg_d    = txreg_q;
    ptr_d      = ptr_q;
    oe_d       = oe_q;
    mack_d     = mack_q;
    to_tx_d    = to_tx_q;
    in_frame_d = in_frame_q;
    wr_armed_d = wr_armed_q;
    wp_ok_d    = wp_ok_q & wp_vclk_i;
    buf_clr    = 1'b0;
    buf_we     = 1'b0;
    launch     = 1'b0;

    if (start_det) begin
      phase_d    = PH_RX;
      kind_d     = RK_CTRL;
      bitcnt_d   = '0;
      oe_d       = 1'b0;
      in_frame_d = 1'b1;
      wr_armed_d = 1'b0;
      wp_ok_d    = wp_vclk_i;
    end else if (stop_det) begin
      if (in_frame_q && wr_armed_q && wp_ok_q && wp_vclk_i && !wr_busy) begin
        launch = 1'b1;
      end
      phase_d    = PH_IDLE;
      oe_d       = 1'b0;
      in_frame_d = 1'b0;
      wr_armed_d = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise && (bitcnt_q != 4'd8)) begin
            shreg_d  = {shreg_q[6:0], sda_lvl};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall && (bitcnt_q == 4'd8)) begin
            bitcnt_d = '0;
            unique case (kind_q)
              RK_CTRL: begin
                if ((shreg_q[7:1] == DEV_ID) && !wr_busy) begin
                  oe_d    = 1'b1;
                  phase_d = PH_ACK;
                  to_tx_d = shreg_q[0];
                  kind_d  = RK_WADDR;
                end else begin
                  phase_d = PH_IDLE;
                end
              end
              RK_WADDR: begin
                ptr_d   = shreg_q[ADDR_W-1:0];
                buf_clr = 1'b1;
                oe_d    = 1'b1;
                phase_d = PH_ACK;
                to_tx_d = 1'b0;
                kind_d  = RK_DATA;
              end
              default: begin
                buf_we     = 1'b1;
                ptr_d      = {ptr_q[ADDR_W-1:PW], ptr_q[PW-1:0] + 1'b1};
                wr_armed_d = 1'b1;
                oe_d       = 1'b1;
                phase_d    = PH_ACK;
                to_tx_d    = 1'b0;
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            if (to_tx_q) begin
              txreg_d  = mem_rdata_i;
              oe_d     = ~mem_rdata_i[7];
              bitcnt_d = 4'd1;
              ptr_d    = ptr_q + 1'b1;
              phase_d  = PH_TX;
            end else begin
              oe_d     = 1'b0;
              bitcnt_d = '0;
              phase_d  = PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              oe_d    = 1'b0;
              mack_d  = 1'b0;
              phase_d = PH_MACK;
            end else begin
              oe_d     = ~txreg_q[6];
              txreg_d  = {txreg_q[6:0], 1'b0};
              bitcnt_d = bitcnt_q + 1'b1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              txreg_d  = mem_rdata_i;
              oe_d     = ~mem_rdata_i[7];
              bitcnt_d = 4'd1;
              ptr_d    = ptr_q + 1'b1;
              phase_d  = PH_TX;
            end else begin
              phase_d = PH_IDLE;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q    <= PH_IDLE;
      kind_q     <= RK_CTRL;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      txreg_q    <= '0;
      ptr_q      <= '0;
      oe_q       <= 1'b0;
      mack_q     <= 1'b0;
      to_tx_q    <= 1'b0;
      wp_ok_q    <= 1'b0;
      in_frame_q <= 1'b0;
      wr_armed_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      kind_q     <= kind_d;
      bitcnt_q   <= bitcnt_d;
      shreg_q    <= shreg_d;
      txreg_q    <= txreg_d;
      ptr_q      <= ptr_d;
      oe_q       <= oe_d;
      mack_q     <= mack_d;
      to_tx_q    <= to_tx_d;
      wp_ok_q    <= wp_ok_d;
      in_frame_q <= in_frame_d;
      wr_armed_q <= wr_armed_d;
    end
  end

  page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (buf_clr),
    .wr_en    (buf_we),
    .wr_idx   (ptr_q[PW-1:0]),
    .wr_data  (shreg_q),
    .rd_idx   (eng_idx),
    .rd_data  (eng_data),
    .rd_valid (eng_valid)
  );

  write_engine #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .launch     (launch),
    .page_base  (ptr_q[ADDR_W-1:PW]),
    .slot_valid (eng_valid),
    .slot_idx   (eng_idx),
    .busy       (wr_busy),
    .we         (mem_we_o),
    .waddr      (mem_waddr_o)
  );

  assign sda_oe_o    = oe_q;
  assign mem_wdata_o = eng_data;
  assign mem_raddr_o = ptr_q;

endmodule

// File: rtl/ddc_eeprom_slave_chk.sv
module ddc_eeprom_slave_chk #(
  parameter int ADDR_W     = 7,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 200,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic               busy,
  input logic               mem_we,
  input logic [ADDR_W-PW-1:0] mem_page
);

  int run_len;
  int we_in_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= 0;
      we_in_run <= 0;
    end else begin
      run_len   <= busy ? run_len + 1 : 0;
      we_in_run <= busy ? we_in_run + (mem_we ? 1 : 0) : 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!sda_oe && !mem_we); // R11
    end
  end

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i); // R2

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_page == $past(mem_page))); // R3

  AST_PAGE_WRITES_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    we_in_run <= PAGE_BYTES); // R4

  AST_COMMIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == WR_CYCLES)); // R5

  AST_WE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (run_len < PAGE_BYTES + 1)); // R5

  AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R6

endmodule

bind ddc_eeprom_slave ddc_eeprom_slave_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .WR_CYCLES  (WR_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe_o),
  .busy     (wr_busy),
  .mem_we   (mem_we_o),
  .mem_page (mem_waddr_o[ADDR_W-1:PW])
);

// File: tb/ddc_eeprom_slave_tb.sv
module ddc_eeprom_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int WRC        = 600;

  logic clk = 1'b0;
  logic rst_n;
  logic scl;
  logic sda_m;
  logic vclk;
  wire  sda_line;
  logic sda_oe;
  logic mem_we;
  logic [6:0] waddr, raddr;
  logic [7:0] wdata, rdata;

  logic [7:0] mem  [128];
  logic [7:0] expm [128];
  logic [7:0] wbuf [16];
  logic [6:0] pmod;
  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  ddc_eeprom_slave #(.WR_CYCLES(WRC)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .wp_vclk_i   (vclk),
    .mem_we_o    (mem_we),
    .mem_waddr_o (waddr),
    .mem_wdata_o (wdata),
    .mem_raddr_o (raddr),
    .mem_rdata_i (rdata)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[waddr] <= wdata;
      we_cnt     <= we_cnt + 1;
    end
  end
  assign rdata = mem[raddr];

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 195000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=timeout exp=completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hq();
    scl   = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl   = 1'b0; hq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hq();
    scl   = 1'b1; hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      hq(); sda_m = b[i];
      hq(); scl = 1'b1;
      hq(); hq(); scl = 1'b0;
    end
    hq(); sda_m = 1'b1;
    hq(); scl = 1'b1;
    hq(); ack = ~sda_line;
    hq(); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      hq(); hq(); scl = 1'b1;
      hq(); b = {b[6:0], sda_line};
      hq(); scl = 1'b0;
    end
    hq(); sda_m = mack ? 1'b0 : 1'b1;
    hq(); scl = 1'b1;
    hq(); hq(); scl = 1'b0;
    hq(); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input int dip_at,
                          input bit vc, input string req);
    bit ack;
    vclk = vc;
    i2c_start();
    send_byte(8'hA0, ack); chk({req, " ctrl ack"}, ack, 1);
    send_byte({1'b0, a}, ack); chk({req, " R2 waddr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      if (i == dip_at) begin vclk = 1'b0; hq(); vclk = 1'b1; end
      send_byte(wbuf[i], ack); chk({req, " R2 data ack"}, ack, 1);
    end
    i2c_stop();
    if (vc && dip_at < 0) begin
      for (int i = 0; i < n; i++) expm[{a[6:3], 3'(a[2:0] + 3'(i))}] = wbuf[i];
    end
    pmod = {a[6:3], 3'(a[2:0] + 3'(n))};
  endtask

  task automatic poll(output int nacks);
    bit ack;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      i2c_start();
      send_byte(8'hA0, ack);
      i2c_stop();
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic do_read(input bit rnd, input logic [6:0] a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    if (rnd) begin
      i2c_start();
      send_byte(8'hA0, ack); chk({req, " R10 ctrl ack"}, ack, 1);
      send_byte({1'b0, a}, ack); chk({req, " R10 waddr ack"}, ack, 1);
      pmod = a;
    end
    i2c_start();
    send_byte(8'hA1, ack); chk({req, " R1 read ctrl ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(req, b, expm[pmod]);
      pmod = pmod + 1'b1;
    end
    i2c_stop();
    chk({req, " R9 sda released"}, sda_oe, 0);
  endtask

  initial begin
    int nk, base, dummy;
    bit ack;
    logic [7:0] b;
    dummy = $urandom(32'h1A2B);
    for (int i = 0; i < 128; i++) begin
      mem[i]  = init_val(i);
      expm[i] = init_val(i);
    end
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; vclk = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 reset oe", sda_oe, 0);
    chk("R11 reset we", mem_we, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 after reset oe", sda_oe, 0);
    chk("R11 after reset we", mem_we, 0);

    // R1: wrong identity, then following byte still ignored
    i2c_start();
    send_byte(8'hA2, ack); chk("R1 wrong id nack", ack, 0);
    send_byte(8'h00, ack); chk("R1 silent until start", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'hB0, ack); chk("R1 wrong id nack", ack, 0);
    i2c_stop();

    // R2/R5/R6: byte write, polling
    base = we_cnt;
    wbuf[0] = 8'h5A;
    do_write(7'h23, 1, -1, 1'b1, "R2");
    poll(nk);
    chk("R6 first poll refused", (nk > 0) ? 1 : 0, 1);
    chk("R6 poll ends", (nk < 40) ? 1 : 0, 1);
    chk("R5 one array write", we_cnt - base, 1);
    do_read(1'b1, 7'h23, 1, "R2 readback");
    // R8: current address after read
    do_read(1'b0, 7'h00, 1, "R8 current after read");

    // R3: page wrap from 0x35
    base = we_cnt;
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hC0 + 8'(i);
    do_write(7'h35, 8, -1, 1'b1, "R3");
    poll(nk);
    chk("R5 eight array writes", we_cnt - base, 8);
    chk("R3 wrapped 0x30", mem[7'h30], 8'hC3);
    chk("R3 neighbour page untouched", mem[7'h38], init_val(8'h38));
    do_read(1'b1, 7'h30, 8, "R3 page readback");

    // R4: overrun of 11 bytes at 0x40
    base = we_cnt;
    for (int i = 0; i < 11; i++) wbuf[i] = 8'h90 + 8'(i);
    do_write(7'h40, 11, -1, 1'b1, "R4");
    poll(nk);
    chk("R4 at most eight writes", we_cnt - base, 8);
    chk("R4 slot0 last value", mem[7'h40], 8'h98);
    chk("R4 slot3 first value", mem[7'h43], 8'h93);
    // R8: current after write
    do_read(1'b0, 7'h00, 2, "R8 current after write");

    // R7: level low for whole frame
    base = we_cnt;
    for (int i = 0; i < 3; i++) wbuf[i] = 8'h11;
    do_write(7'h50, 3, -1, 1'b0, "R7 low");
    vclk = 1'b1;
    poll(nk);
    chk("R7 discarded no busy", nk, 0);
    chk("R7 discarded no write", we_cnt - base, 0);
    // R7: brief dip inside a data byte
    do_write(7'h50, 3, 1, 1'b1, "R7 dip");
    poll(nk);
    chk("R7 dip no busy", nk, 0);
    chk("R7 dip no write", we_cnt - base, 0);
    chk("R7 dip cell kept", mem[7'h51], init_val(8'h51));
    // R7: level toggles during commit
    for (int i = 0; i < 2; i++) wbuf[i] = 8'h66 + 8'(i);
    do_write(7'h58, 2, -1, 1'b1, "R7 busy toggle");
    vclk = 1'b0; repeat (20) @(negedge clk); vclk = 1'b1;
    repeat (10) @(negedge clk); vclk = 1'b0;
    poll(nk);
    vclk = 1'b1;
    chk("R7 commit survives toggle", mem[7'h59], 8'h67);

    // R9: sequential read wrapping 0x7F -> 0x00
    do_read(1'b1, 7'h7E, 4, "R9 wrap read");

    // R10: repeated start after data cancels commit
    base = we_cnt;
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'h60, ack);
    send_byte(8'hEE, ack);
    send_byte(8'hEF, ack);
    i2c_start();
    send_byte(8'hA1, ack); chk("R10 read after restart ack", ack, 1);
    recv_byte(1'b0, b);
    chk("R10 read at pointer", b, expm[7'h62]);
    i2c_stop();
    poll(nk);
    chk("R10 no commit busy", nk, 0);
    chk("R10 no commit write", we_cnt - base, 0);
    pmod = 7'h63;

    // random traffic
    for (int it = 0; it < 12; it++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom % 128);
      n = 1 + int'($urandom % 10);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      base = we_cnt;
      do_write(a, n, -1, 1'b1, "R3 random");
      poll(nk);
      chk("R5 random write count", we_cnt - base, (n > 8) ? 8 : n);
      if (it % 2 == 0) do_read(1'b0, 7'h00, 2, "R8 random current");
      do_read(1'b1, 7'($urandom % 128), 1 + int'($urandom % 6), "R9 random read");
    end

    summary();
    $finish;
  end

endmodule